// File: doc/BRIEF.md
# Event-Selectable Performance Counter

This block is one performance-monitor counter for a processor core. Every clock it sees a vector of single-cycle event pulses from the core and two external trace-output lines. An 8-bit select code chooses which condition is counted. Depending on that condition, the count grows by 0, 1 or 2 in each cycle.

Software-facing plumbing lives elsewhere. This block has an enable, a synchronous clear, the running count and a sticky wrap flag. Two event codes can add two in a single cycle, because a companion "second occurrence" bit on the event vector reports that a paired event also happened. Code 0x22 adds two when both trace lines are high together. Code 0xFF ignores all inputs and counts clock cycles.

Top module: `perf_event_counter`

## Requirements
- R1: Asynchronous reset drives the count and the wrap flag to zero. When `clr` is high at a clock edge, both become zero at that edge, whatever `en` is.
- R2: With select code 0xFF and `en` high, the count rises by exactly one on every clock, whatever the event and trace inputs are.
- R3: Each single-occurrence code maps to one bit of `evt_bus`. The codes 0x00–0x07, 0x09–0x0D, 0x0F–0x12 and 0x23–0x26 take bit numbers from 0 upward in ascending code order, and bits 9 and 15 are skipped. The count adds one in every enabled cycle in which the mapped bit is high. This applies to every stall code (0x01, 0x02, 0x11) in every cycle of the stall.
- R4: Code 0x07 (bit 7) adds two when bit 9 is also high. Code 0x0D (bit 13) adds two when bit 15 is also high. A second-occurrence bit alone adds nothing.
- R5: Code 0x20 counts cycles with `trace_out[0]` high, and code 0x21 counts cycles with `trace_out[1]` high. Code 0x22 adds the number of trace lines high in that cycle (0, 1 or 2).
- R6: Codes 0x08, 0x0E, 0x13–0x1F and 0x27–0xFE never change the count, whatever the inputs are.
- R7: While `en` is low and `clr` is low, the count and the wrap flag hold their values.
- R8: The count is `CNT_W` bits wide (default 32) and wraps modulo 2^CNT_W. Any enabled step that passes the top value sets the wrap flag, including a step of two from the top value or from one below it.
- R9: A new select code takes effect at the next clock edge and does not disturb the accumulated count.
- R10: Once set, the wrap flag stays set until `clr` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counting enable |
| clr | input | 1 | Synchronous clear of the count and the wrap flag |
| evt_sel | input | 8 | Event select code |
| evt_bus | input | 23 | Event pulses from the core, including second-occurrence bits 9 and 15 |
| trace_out | input | 2 | External trace-output lines |
| cnt_o | output | CNT_W | Current count |
| wrap_o | output | 1 | Sticky wrap flag |

## Verification
The embedded properties check on every cycle that a clear zeroes the state and that a disabled counter holds. They also check that cycle mode steps by exactly one, that unmapped codes leave the count alone, that no step exceeds two, and that the wrap flag is sticky. The code-to-bit map, the doubling rules on the trace lines and on bits 9 and 15, and the exact wrap values after a double step can only be shown by the bench scenarios. For these, the bench sweeps all 256 codes against an independently computed reference and drives the count across the top with a narrowed width.

// File: rtl/perf_event_counter.sv
module perf_event_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [7:0]       evt_sel,
  input  logic [22:0]      evt_bus,
  input  logic [1:0]       trace_out,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic       hit;
  logic       dbl;
  logic [1:0] step;
  logic [CNT_W:0] sum;

  always_comb begin
    hit = 1'b0;
    dbl = 1'b0;
    case (evt_sel)
      8'h00: hit = evt_bus[0];
      8'h01: hit = evt_bus[1];
      8'h02: hit = evt_bus[2];
      8'h03: hit = evt_bus[3];
      8'h04: hit = evt_bus[4];
      8'h05: hit = evt_bus[5];
      8'h06: hit = evt_bus[6];
      8'h07: begin hit = evt_bus[7];  dbl = evt_bus[9];  end
      8'h09: hit = evt_bus[8];
      8'h0A: hit = evt_bus[10];
      8'h0B: hit = evt_bus[11];
      8'h0C: hit = evt_bus[12];
      8'h0D: begin hit = evt_bus[13]; dbl = evt_bus[15]; end
      8'h0F: hit = evt_bus[14];
      8'h10: hit = evt_bus[16];
      8'h11: hit = evt_bus[17];
      8'h12: hit = evt_bus[18];
      8'h23: hit = evt_bus[19];
      8'h24: hit = evt_bus[20];
      8'h25: hit = evt_bus[21];
      8'h26: hit = evt_bus[22];
      default: ;
    endcase
  end

  always_comb begin
    case (evt_sel)
      8'hFF:   step = 2'd1;
      8'h20:   step = {1'b0, trace_out[0]};
      8'h21:   step = {1'b0, trace_out[1]};
      8'h22:   step = {1'b0, trace_out[0]} + {1'b0, trace_out[1]};
      default: step = hit ? (dbl ? 2'd2 : 2'd1) : 2'd0;
    endcase
  end

  assign sum = {1'b0, cnt_o} + {{(CNT_W-1){1'b0}}, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      wrap_o <= 1'b0;
    end else if (clr) begin
      cnt_o  <= '0;
      wrap_o <= 1'b0;
    end else if (en) begin
      cnt_o <= sum[CNT_W-1:0];
      if (sum[CNT_W]) wrap_o <= 1'b1;
    end
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_o == '0) && !wrap_o);

  p_cycles_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && evt_sel == 8'hFF) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

  p_unmapped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && (evt_sel == 8'h08 || evt_sel == 8'h0E ||
     (evt_sel >= 8'h13 && evt_sel <= 8'h1F) || (evt_sel >= 8'h27 && evt_sel <= 8'hFE)))
    |=> $stable(cnt_o));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt_o) && $stable(wrap_o));

  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> CNT_W'(cnt_o - $past(cnt_o)) <= CNT_W'(2));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && evt_sel == 8'hFF && cnt_o == '1) |=> wrap_o && cnt_o == '0);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && !clr) |=> wrap_o);

endmodule

// File: tb/perf_event_counter_tb.sv
module perf_event_counter_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, clr = 1'b0;
  logic [7:0]  evt_sel = 8'h00;
  logic [22:0] evt_bus = '0;
  logic [1:0]  trace_out = 2'b00;
  logic [W-1:0] cnt_o;
  logic wrap_o;

  int n_vec = 0, n_bad = 0;
  logic [W-1:0] m_cnt = '0;
  logic m_wrap = 1'b0;
  logic [W-1:0] q_cnt[$];
  logic         q_wrap[$];
  string        q_tag[$];

  always #4 clk = ~clk;

  perf_event_counter #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .evt_sel(evt_sel),
    .evt_bus(evt_bus), .trace_out(trace_out), .cnt_o(cnt_o), .wrap_o(wrap_o));

  function automatic bit is_single(int c);
    return (c <= 7) || (c >= 9 && c <= 13) || (c >= 15 && c <= 18) || (c >= 35 && c <= 38);
  endfunction

  function automatic int bit_of(int code);
    int b = 0;
    for (int c = 0; c < 256; c++) begin
      if (is_single(c)) begin
        while (b == 9 || b == 15) b++;
        if (c == code) return b;
        b++;
      end
    end
    return -1;
  endfunction

  function automatic int model_step(int code, logic [22:0] bus, logic [1:0] tr);
    int b;
    if (code == 255) return 1;
    if (code == 32) return int'(tr[0]);
    if (code == 33) return int'(tr[1]);
    if (code == 34) return int'(tr[0]) + int'(tr[1]);
    b = bit_of(code);
    if (b < 0 || !bus[b]) return 0;
    return 1 + int'(code == 7 && bus[9]) + int'(code == 13 && bus[15]);
  endfunction

  task automatic apply(input logic e, input logic c, input logic [7:0] s,
                       input logic [22:0] bus, input logic [1:0] tr, input string tag);
    int sum;
    @(negedge clk);
    en = e; clr = c; evt_sel = s; evt_bus = bus; trace_out = tr;
    if (c) begin
      m_cnt = '0; m_wrap = 1'b0;
    end else if (e) begin
      sum = int'(m_cnt) + model_step(int'(s), bus, tr);
      if (sum >= (1 << W)) m_wrap = 1'b1;
      m_cnt = W'(sum);
    end
    q_cnt.push_back(m_cnt); q_wrap.push_back(m_wrap); q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q_cnt.size() > 0) begin
      logic [W-1:0] ec; logic ew; string t;
      ec = q_cnt.pop_front(); ew = q_wrap.pop_front(); t = q_tag.pop_front();
      n_vec++;
      if (cnt_o !== ec || wrap_o !== ew) begin
        n_bad++;
        $display("FAIL %s: cnt=%0d wrap=%0d expected cnt=%0d wrap=%0d", t, cnt_o, wrap_o, ec, ew);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    n_vec++;
    if (cnt_o !== '0 || wrap_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: cnt=%0d wrap=%0d expected cnt=0 wrap=0", cnt_o, wrap_o);
    end
    // R2 cycle mode with busy and quiet inputs
    repeat (3) apply(1, 0, 8'hFF, '0, 2'b00, "R2");
    repeat (2) apply(1, 0, 8'hFF, '1, 2'b11, "R2");
    // R7 hold while disabled
    repeat (3) apply(0, 0, 8'hFF, '1, 2'b11, "R7");
    // R1 clear beats enable
    apply(1, 1, 8'hFF, '1, 2'b11, "R1");
    // R3 stall codes count each cycle of the condition
    repeat (4) apply(1, 0, 8'h01, 23'h000002, 2'b00, "R3");
    repeat (3) apply(1, 0, 8'h11, 23'h020000, 2'b00, "R3");
    apply(1, 0, 8'h02, 23'h000000, 2'b00, "R3");
    // R4 double increments and lone second bits
    apply(1, 0, 8'h07, 23'h000280, 2'b00, "R4");
    apply(1, 0, 8'h07, 23'h000200, 2'b00, "R4");
    apply(1, 0, 8'h0D, 23'h00A000, 2'b00, "R4");
    apply(1, 0, 8'h0D, 23'h008000, 2'b00, "R4");
    // R5 trace lines
    apply(1, 0, 8'h20, '0, 2'b01, "R5");
    apply(1, 0, 8'h21, '0, 2'b01, "R5");
    apply(1, 0, 8'h22, '0, 2'b11, "R5");
    apply(1, 0, 8'h22, '0, 2'b10, "R5");
    // R6 unmapped with everything high
    apply(1, 0, 8'h08, '1, 2'b11, "R6");
    apply(1, 0, 8'h0E, '1, 2'b11, "R6");
    apply(1, 0, 8'hFE, '1, 2'b11, "R6");
    // R9 code change keeps the count
    apply(1, 0, 8'hFF, '0, 2'b00, "R9");
    apply(1, 0, 8'h03, 23'h000008, 2'b00, "R9");
    apply(1, 0, 8'h27, 23'h7FFFFF, 2'b11, "R9");
    // R8 double wrap from the top value
    apply(1, 1, 8'hFF, '0, 2'b00, "R1");
    repeat (255) apply(1, 0, 8'hFF, '0, 2'b00, "R8");
    apply(1, 0, 8'h22, '0, 2'b11, "R8");
    apply(0, 0, 8'hFF, '0, 2'b00, "R10");
    repeat (3) apply(1, 0, 8'hFF, '0, 2'b00, "R10");
    apply(0, 1, 8'hFF, '0, 2'b00, "R10");
    // R8 double wrap from one below the top
    repeat (254) apply(1, 0, 8'hFF, '0, 2'b00, "R8");
    apply(1, 0, 8'h07, 23'h000280, 2'b00, "R8");
    apply(1, 1, 8'h00, '0, 2'b00, "R1");
    // sweep of every code
    for (int c = 0; c < 256; c++) begin
      for (int p = 0; p < 3; p++) begin
        logic [22:0] bus;
        bus = (p == 0) ? 23'h7FFFFF : (p == 1) ? 23'h000000 : 23'h2AAAAA;
        apply(1, 0, 8'(c), bus, 2'(p), (bit_of(c) < 0 && c != 255 && (c < 32 || c > 34)) ? "R6" : "R3");
      end
    end
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule